// File: doc/BRIEF.md
# ECC DRAM access timing sequencer

This block sits between a local-bus master and an error-corrected DRAM array. It accepts single-beat and four-beat burst reads and writes, and it paces the acknowledge of every beat. The read latency depends on two mode inputs. A fast-read bit shortens the first beat of a read by one clock, but only while the error-reporting bit is off. Every read returns the whole 32-bit word, even when the master enables fewer bytes.

A single (non-burst) write is posted. The master gets its acknowledge in the second clock and the bus is free again. The block then runs a background read-modify-write of eight clocks. In that cycle the enabled bytes are merged into the stored word, the per-byte check bits are recomputed, and the whole word is written back. Any access that arrives during the busy period waits without an acknowledge. A simple per-byte parity stands in for the real check-bit code.

Two snoop-control inputs decide whether the memory-inhibit input matters. In the code 2'b11 (snooping inhibited) memory-inhibit is ignored. In any other code an asserted memory-inhibit stops the block from taking the access.

Top module: `dram_access_seq`

## Requirements
- R1: Clock numbering: clock 1 is the cycle in which the block is idle and samples req_valid high; acknowledges are counted from there. With fast_read=1 and err_report=0, a single read acknowledges in clock 4. A burst read acknowledges in clocks 4, 5, 6 and 7.
- R2: With fast_read=0 and err_report=0, a single read acknowledges in clock 5. A burst read acknowledges in clocks 5 to 8.
- R3: With err_report=1, reads acknowledge first in clock 5 (bursts in clocks 5 to 8), for either value of fast_read.
- R4: A single write (req_write=1, req_burst=0) acknowledges in clock 2, using the address, byte enables and data sampled in clock 1.
- R5: After a single-write acknowledge, rmw_busy is high for exactly 8 clocks (clocks 3 to 10). The merged word is in the array by the time rmw_busy falls.
- R6: A request made while rmw_busy is high gets no acknowledge until rmw_busy falls. The first clock after the busy period then counts as its clock 1. A fast read issued in clock 3 of a single write therefore acknowledges in clock 14.
- R7: A burst write acknowledges in clocks 2, 3, 4 and 5 and never raises rmw_busy. Beat k writes all four bytes of req_wdata, as present in its acknowledge clock, to word {addr[3:2], addr[1:0]+k} (the low two bits wrap).
- R8: During each read acknowledge, rdata_oe=1 and rdata carries the full 32-bit stored word, whatever req_be is. Burst beat k reads word {addr[3:2], addr[1:0]+k}.
- R9: When snoop_ctl=2'b11, mem_inhibit has no effect: accesses complete with the R1 to R7 timing and data.
- R10: When snoop_ctl is not 2'b11 and mem_inhibit=1, a request gets no acknowledge, rdata_oe stays 0, rdata stays 0 and the array is not written.
- R11: A single write replaces byte b (bits 8b+7:8b) of the stored word only where req_be[b]=1, keeps the other bytes, and stores fresh check bits for the merged word.
- R12: While rst_n=0, ack, rdata_oe and rmw_busy are 0 and rdata is 0. A reset clears any read-modify-write in progress and zeroes the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until the last acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single beat |
| req_addr | input | AW | Word address |
| req_be | input | 4 | Byte enables for a single write |
| req_wdata | input | 32 | Write data (per beat for bursts) |
| snoop_ctl | input | 2 | Snoop control; 2'b11 = snooping inhibited |
| mem_inhibit | input | 1 | Memory inhibit from a snooping cache |
| fast_read | input | 1 | Fast-read mode |
| err_report | input | 1 | Error-reporting mode |
| ack | output | 1 | Beat acknowledge |
| rdata | output | 32 | Read data, zero outside read beats |
| rdata_oe | output | 1 | Read data drive enable |
| rmw_busy | output | 1 | Background read-modify-write in progress |

## Verification
Each result has a fixed due clock counted from the cycle that samples the request. A write acknowledge is due in clock 2 and a read's first beat in clock 4 or 5; each further burst beat follows one clock later. The busy flag covers clocks 3 to 10, and a held request is due 8 clocks later than usual. The bench drives and samples on falling edges and counts falling edges from the one after it raised the request. It compares the clock number of every acknowledge with its due clock, and it compares the data of each read beat with a model of the array that it updates itself. The cases where an input must have no effect are checked with the same method. Under inhibit, the bench looks for any acknowledge or data drive, then reads the target word back once inhibit is released.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAT,
    ST_BEAT,
    ST_RMW
  } seq_state_t;

  // placeholder check code: one parity bit per byte lane
  function automatic logic [LANES-1:0] lane_check(input logic [DATA_W-1:0] w);
    logic [LANES-1:0] c;
    for (int i = 0; i < LANES; i++) begin
      c[i] = ^w[8*i +: 8];
    end
    return c;
  endfunction

  // clocks from request to first read beat, counting the request clock
  function automatic int unsigned read_cycles(input logic fast, input logic errmode,
                                              input int unsigned quick, input int unsigned slow);
    return (fast && !errmode) ? quick : slow;
  endfunction

endpackage

// File: rtl/dseq_array.sv
module dseq_array #(
  parameter int unsigned AW = 4,
  parameter int unsigned WW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wword,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rword
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '0;
      end
    end else if (we) begin
      mem[waddr] <= wword;
    end
  end

  assign rword = mem[raddr];

endmodule

// File: rtl/dseq_merge.sv
module dseq_merge #(
  parameter int unsigned LANES = 4
) (
  input  logic [8*LANES-1:0] old_word,
  input  logic [8*LANES-1:0] new_word,
  input  logic [LANES-1:0]   lane_en,
  output logic [8*LANES-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = lane_en[g] ? new_word[8*g +: 8] : old_word[8*g +: 8];
  end
endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
  import dseq_pkg::*;
#(
  parameter int unsigned AW          = 4,
  parameter int unsigned BEATS       = 4,
  parameter int unsigned WR_LAT      = 2,
  parameter int unsigned FAST_RD_LAT = 4,
  parameter int unsigned SLOW_RD_LAT = 5,
  parameter int unsigned RMW_CYCLES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [AW-1:0]     req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              inh_active,
  input  logic              fast_read,
  input  logic              err_report,
  input  logic [DATA_W-1:0] rword_data,
  output logic              ack,
  output logic              rd_beat,
  output logic              posted_ack,
  output logic              accept,
  output logic              idle,
  output logic              busy,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [AW-1:0]     mem_raddr
);
  localparam int unsigned BEAT_W  = $clog2(BEATS);
  localparam int unsigned CNT_MAX = (RMW_CYCLES > SLOW_RD_LAT) ? RMW_CYCLES : SLOW_RD_LAT;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BEAT_W-1:0] beat;
  logic [AW-1:0]     hold_addr;
  logic              hold_write;
  logic              hold_burst;
  logic [LANES-1:0]  hold_be;
  logic [DATA_W-1:0] hold_wdata;
  logic [DATA_W-1:0] rmw_old;
  logic [DATA_W-1:0] merged_word;
  logic [AW-1:0]     beat_addr;
  logic              last_beat;
  logic              rmw_commit;
  logic              burst_wr_beat;
  int unsigned       lat_now;

  assign idle    = (state == ST_IDLE);
  assign accept  = idle && req_valid && !inh_active;
  assign lat_now = req_write ? WR_LAT : read_cycles(fast_read, err_report, FAST_RD_LAT, SLOW_RD_LAT);

  assign ack           = (state == ST_BEAT);
  assign rd_beat       = ack && !hold_write;
  assign burst_wr_beat = ack && hold_write && hold_burst;
  assign posted_ack    = ack && hold_write && !hold_burst;
  assign busy          = (state == ST_RMW);
  assign rmw_commit    = busy && (cnt == '0);
  assign last_beat     = !hold_burst || (beat == BEAT_W'(BEATS - 1));

  // burst beats wrap inside the aligned line
  assign beat_addr = {hold_addr[AW-1:BEAT_W], hold_addr[BEAT_W-1:0] + beat};

  assign mem_we    = burst_wr_beat || rmw_commit;
  assign mem_waddr = rmw_commit ? hold_addr : beat_addr;
  assign mem_wdata = rmw_commit ? merged_word : req_wdata;
  assign mem_raddr = busy ? hold_addr : beat_addr;

  dseq_merge #(.LANES(LANES)) u_merge (
    .old_word (rmw_old),
    .new_word (hold_wdata),
    .lane_en  (hold_be),
    .merged   (merged_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      beat       <= '0;
      hold_addr  <= '0;
      hold_write <= 1'b0;
      hold_burst <= 1'b0;
      hold_be    <= '0;
      hold_wdata <= '0;
      rmw_old    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            hold_addr  <= req_addr;
            hold_write <= req_write;
            hold_burst <= req_burst;
            hold_be    <= req_be;
            hold_wdata <= req_wdata;
            beat       <= '0;
            if (lat_now <= 32'd2) begin
              state <= ST_BEAT;
            end else begin
              state <= ST_LAT;
              cnt   <= CNT_W'(lat_now - 32'd3);
            end
          end
        end
        ST_LAT: begin
          if (cnt == '0) state <= ST_BEAT;
          else           cnt   <= cnt - 1'b1;
        end
        ST_BEAT: begin
          if (last_beat) begin
            if (hold_write && !hold_burst) begin
              state <= ST_RMW;
              cnt   <= CNT_W'(RMW_CYCLES - 1);
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            beat <= beat + 1'b1;
          end
        end
        ST_RMW: begin
          // first busy clock reads the stored word; last one writes it back
          if (cnt == CNT_W'(RMW_CYCLES - 1)) rmw_old <= rword_data;
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dseq_pkg::*;
#(
  parameter int unsigned AW          = 4,
  parameter int unsigned BEATS       = 4,
  parameter int unsigned WR_LAT      = 2,
  parameter int unsigned FAST_RD_LAT = 4,
  parameter int unsigned SLOW_RD_LAT = 5,
  parameter int unsigned RMW_CYCLES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [AW-1:0]     req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        snoop_ctl,
  input  logic              mem_inhibit,
  input  logic              fast_read,
  input  logic              err_report,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              rmw_busy
);
  localparam logic [1:0]  SNOOP_OFF = 2'b11;
  localparam int unsigned WW        = DATA_W + LANES;

  logic              inh_active;
  logic              seq_accept;
  logic              seq_idle;
  logic              seq_posted_ack;
  logic              rd_beat;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [AW-1:0]     mem_raddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [WW-1:0]     mem_wword;
  logic [WW-1:0]     rword;
  logic [DATA_W-1:0] rword_data;
  logic [LANES-1:0]  rword_chk;
  logic              rd_chk_ok;

  assign inh_active = mem_inhibit && (snoop_ctl != SNOOP_OFF);

  dseq_ctrl #(
    .AW(AW), .BEATS(BEATS), .WR_LAT(WR_LAT), .FAST_RD_LAT(FAST_RD_LAT),
    .SLOW_RD_LAT(SLOW_RD_LAT), .RMW_CYCLES(RMW_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_burst  (req_burst),
    .req_addr   (req_addr),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .inh_active (inh_active),
    .fast_read  (fast_read),
    .err_report (err_report),
    .rword_data (rword_data),
    .ack        (ack),
    .rd_beat    (rd_beat),
    .posted_ack (seq_posted_ack),
    .accept     (seq_accept),
    .idle       (seq_idle),
    .busy       (rmw_busy),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_raddr  (mem_raddr)
  );

  assign mem_wword = {lane_check(mem_wdata), mem_wdata};

  dseq_array #(.AW(AW), .WW(WW)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wword (mem_wword),
    .raddr (mem_raddr),
    .rword (rword)
  );

  assign rword_data = rword[DATA_W-1:0];
  assign rword_chk  = rword[DATA_W +: LANES];
  assign rd_chk_ok  = (lane_check(rword_data) == rword_chk);

  assign rdata_oe = rd_beat;
  assign rdata    = rd_beat ? rword_data : '0;

endmodule

// File: rtl/dseq_checker.sv
module dseq_checker #(
  parameter int unsigned RMW_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_write,
  input logic       req_burst,
  input logic [1:0] snoop_ctl,
  input logic       mem_inhibit,
  input logic       fast_read,
  input logic       err_report,
  input logic       ack,
  input logic       rdata_oe,
  input logic       rmw_busy,
  input logic       seq_accept,
  input logic       seq_idle,
  input logic       seq_posted_ack,
  input logic       rd_chk_ok
);
  logic [7:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_len <= '0;
    else if (rmw_busy) busy_len <= busy_len + 8'd1;
    else               busy_len <= '0;
  end

  assert_fast_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept && !req_write && fast_read && !err_report |=> !ack ##1 !ack ##1 ack);

  assert_slow_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept && !req_write && !fast_read |=> !ack ##1 !ack ##1 !ack ##1 ack);

  assert_err_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept && !req_write && err_report |=> !ack ##1 !ack ##1 !ack ##1 ack);

  assert_posted_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept && req_write && !req_burst |=> ack);

  assert_busy_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_posted_ack |=> rmw_busy);

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rmw_busy && $past(rmw_busy)) |-> (busy_len == 8'(RMW_CYCLES)));

  assert_burst_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept && req_write && req_burst |=> ack ##1 ack ##1 ack ##1 ack ##1 !rmw_busy);

  assert_snoop_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle && req_valid && (snoop_ctl == 2'b11) |-> seq_accept);

  assert_inhibit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle && mem_inhibit && (snoop_ctl != 2'b11) |=> !ack && !rdata_oe);

  assert_check_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> rd_chk_ok);

endmodule

bind dram_access_seq dseq_checker #(.RMW_CYCLES(RMW_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_write      (req_write),
  .req_burst      (req_burst),
  .snoop_ctl      (snoop_ctl),
  .mem_inhibit    (mem_inhibit),
  .fast_read      (fast_read),
  .err_report     (err_report),
  .ack            (ack),
  .rdata_oe       (rdata_oe),
  .rmw_busy       (rmw_busy),
  .seq_accept     (seq_accept),
  .seq_idle       (seq_idle),
  .seq_posted_ack (seq_posted_ack),
  .rd_chk_ok      (rd_chk_ok)
);

// File: tb/tb_dram_access_seq.sv
module tb_dram_access_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_burst = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  snoop_ctl = 2'b00;
  logic        mem_inhibit = 1'b0;
  logic        fast_read = 1'b1;
  logic        err_report = 1'b0;
  logic        ack;
  logic [31:0] rdata;
  logic        rdata_oe;
  logic        rmw_busy;

  int          n_checks = 0;
  int          n_err = 0;
  bit          done = 1'b0;
  logic [31:0] model [16];
  logic [7:0]  seed = 8'h11;

  always #5 clk = ~clk;

  dram_access_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_burst(req_burst), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .snoop_ctl(snoop_ctl), .mem_inhibit(mem_inhibit), .fast_read(fast_read),
    .err_report(err_report), .ack(ack), .rdata(rdata), .rdata_oe(rdata_oe),
    .rmw_busy(rmw_busy)
  );

  typedef struct packed {
    logic       wr;
    logic       bu;
    logic       fa;
    logic       er;
    logic [3:0] addr;
    logic [3:0] be;
    logic [7:0] lat;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'h1, 4'hF, 8'd4},
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'h6, 4'hF, 8'd4},
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'h2, 4'h1, 8'd5},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'h9, 4'hF, 8'd5},
    '{1'b0, 1'b0, 1'b1, 1'b1, 4'h3, 4'h2, 8'd5},
    '{1'b0, 1'b1, 1'b0, 1'b1, 4'hC, 4'hF, 8'd5},
    '{1'b1, 1'b0, 1'b1, 1'b0, 4'h5, 4'h6, 8'd2},
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'hB, 4'hF, 8'd2}
  };

  function automatic logic [31:0] wpat(input logic [3:0] a, input int k);
    return {seed, 4'h0, a, 8'h5A ^ 8'(k), 8'hC3 + 8'(k)};
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one bus access; exp_lat is the clock of the first acknowledge
  task automatic run_access(input logic w, input logic bu, input logic [3:0] a,
                            input logic [3:0] be, input int exp_lat, input string tag);
    int          n_beats;
    int          cyc;
    int          got;
    logic [3:0]  ba;
    logic [31:0] m;
    n_beats = bu ? 4 : 1;
    seed    = seed + 8'd7;
    m       = lane_mask(be);
    @(negedge clk);
    req_write = w; req_burst = bu; req_addr = a; req_be = be;
    req_wdata = wpat(a, 0);
    req_valid = 1'b1;
    cyc = 1;
    got = 0;
    while (got < n_beats && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (w && bu) req_wdata = wpat(a, got);
      if (ack) begin
        ba = bu ? ((a & 4'hC) | ((a + 4'(got)) & 4'h3)) : a;
        check(cyc == exp_lat + got, tag, "beat clock", 32'(cyc), 32'(exp_lat + got));
        if (w) begin
          if (bu) model[ba] = wpat(a, got);
          else    model[ba] = (model[ba] & ~m) | (wpat(a, 0) & m);
        end else begin
          check(rdata_oe && rdata == model[ba], tag, "read data", rdata, model[ba]);
        end
        got++;
        if (got == n_beats) req_valid = 1'b0;
      end
    end
    if (got != n_beats) begin
      check(1'b0, tag, "beats seen", 32'(got), 32'(n_beats));
      req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    int bad;
    for (int i = 0; i < 16; i++) model[i] = '0;

    // R12: outputs quiet during reset
    repeat (3) @(negedge clk);
    check(!ack && !rdata_oe && !rmw_busy && rdata == '0, "R12", "outputs in reset",
          {ack, rdata_oe, rmw_busy}, 32'd0);
    rst_n = 1'b1;

    // preload every word with burst writes (R7)
    for (int l = 0; l < 4; l++) run_access(1'b1, 1'b1, 4'(4 * l), 4'hF, 2, "R7");

    // table of modes and access kinds
    for (int v = 0; v < NVEC; v++) begin
      string t;
      fast_read  = VECS[v].fa;
      err_report = VECS[v].er;
      if (VECS[v].wr && VECS[v].bu) t = "R7";
      else if (VECS[v].wr)          t = "R4";
      else if (VECS[v].er)          t = "R3";
      else if (!VECS[v].fa)         t = "R2";
      else                          t = "R1";
      run_access(VECS[v].wr, VECS[v].bu, VECS[v].addr, VECS[v].be, int'(VECS[v].lat), t);
      repeat (10) @(negedge clk);
    end
    fast_read = 1'b1; err_report = 1'b0;

    // R8: narrow byte enable still returns the whole word
    run_access(1'b0, 1'b0, 4'h5, 4'h1, 4, "R8");

    // R5 and R11: busy window and byte merge
    run_access(1'b1, 1'b0, 4'h7, 4'b1001, 2, "R11");
    for (int c = 3; c <= 11; c++) begin
      @(negedge clk);
      check(rmw_busy == (c <= 10), "R5", "busy window", 32'(rmw_busy), 32'(c <= 10));
    end
    run_access(1'b0, 1'b0, 4'h7, 4'hF, 4, "R11");

    // R6: read issued in clock 3 of a posted write
    run_access(1'b1, 1'b0, 4'h2, 4'hF, 2, "R6");
    run_access(1'b0, 1'b0, 4'h2, 4'hF, 12, "R6");
    repeat (4) @(negedge clk);

    // R10: inhibit with snooping enabled
    snoop_ctl = 2'b01; mem_inhibit = 1'b1;
    @(negedge clk);
    req_write = 1'b1; req_burst = 1'b0; req_addr = 4'h3; req_be = 4'hF;
    req_wdata = 32'hDEAD_BEEF; req_valid = 1'b1;
    bad = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (ack || rdata_oe || rdata != '0) bad++;
    end
    req_write = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (ack || rdata_oe || rdata != '0) bad++;
    end
    req_valid = 1'b0;
    check(bad == 0, "R10", "activity under inhibit", 32'(bad), 32'd0);
    mem_inhibit = 1'b0; snoop_ctl = 2'b00;
    run_access(1'b0, 1'b0, 4'h3, 4'hF, 4, "R10");

    // R9: snoop inhibited code masks memory inhibit
    snoop_ctl = 2'b11; mem_inhibit = 1'b1;
    run_access(1'b0, 1'b0, 4'h5, 4'hF, 4, "R9");
    run_access(1'b1, 1'b0, 4'h8, 4'b0110, 2, "R9");
    repeat (10) @(negedge clk);
    run_access(1'b0, 1'b1, 4'h8, 4'hF, 4, "R9");
    snoop_ctl = 2'b00; mem_inhibit = 1'b0;

    // R12: reset during a read-modify-write
    run_access(1'b1, 1'b0, 4'h1, 4'hF, 2, "R12");
    @(negedge clk);
    check(rmw_busy, "R12", "busy before reset", 32'(rmw_busy), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!rmw_busy && !ack, "R12", "busy cleared", {ack, rmw_busy}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) model[i] = '0;
    run_access(1'b0, 1'b0, 4'h1, 4'hF, 4, "R12");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule